// File: doc/BRIEF.md
# ADC Conversion Sequencer and Result Buffer

This block is the digital side of a successive-approximation converter. A converter that is not part of this block reports each finished conversion as a one-cycle strobe with a 10-bit code. The block stores each code in a 32-word result memory and counts the conversions that make up one sequence. At the end of each sequence it raises an interrupt pulse. The memory works in one of two ways. It is either one linear 32-word store, or two 16-word halves that take turns, so that software can read one half while the other half fills.

The block also tells the converter which analog input to sample next. There are three ways to choose it. The first is a fixed primary channel. The second alternates between the primary channel and a secondary channel. The third walks the primary selection through a 16-bit mask of enabled inputs. A combinational read port returns any stored word by address. A status flag names the half that is filling now.

Configuration is static while conversions run. It is applied while reset is held.

Top module: `adc_seq_top`

## Requirements
- R1: With count field N (cfg_count, 0..31), irq is a one-cycle pulse after every N+1 conversions in single mode. It goes high in the cycle that follows the clock edge storing the last result of the sequence, and it is low in the next cycle when no new strobe arrives.
- R2: In single mode (cfg_split=0), the k-th result of a sequence (k from 0) is written to address k. After each irq the next result goes to address 0.
- R3: In split mode (cfg_split=1), a sequence fills one 16-word half: base 0 when fill_upper=0 and base 16 when fill_upper=1. The length of a sequence is N+1, clamped to 16.
- R4: fill_upper is 0 after reset. In split mode it inverts at every irq, where 1 means the upper half (16..31) is filling. In single mode it stays 0.
- R5: With cfg_alt=0, next_is_b is always 0. With cfg_scan=0, next_chan equals cfg_cha.
- R6: With cfg_alt=1, the first sample of each sequence uses the primary selection (next_is_b=0). Later samples alternate secondary, primary, secondary and so on, and a secondary sample presents cfg_chb.
- R7: With cfg_scan=1 and a non-zero scan_mask, each primary sample presents the next set mask bit in ascending order. The walk wraps to the lowest set bit and restarts from the lowest set bit at each irq. With an all-zero mask, the primary sample presents cfg_cha.
- R8: After reset, irq=0, fill_upper=0, next_is_b=0, and every buffer word reads 0.
- R9: rd_data shows the word at rd_addr in the same cycle. A word keeps its value until a later conversion writes that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_split | input | 1 | 1 = two 16-word halves, 0 = one 32-word buffer |
| cfg_alt | input | 1 | 1 = alternate primary and secondary input selection |
| cfg_scan | input | 1 | 1 = walk scan_mask on primary samples |
| cfg_count | input | 5 | Conversions per interrupt minus one |
| cfg_cha | input | 4 | Fixed primary channel |
| cfg_chb | input | 4 | Secondary channel |
| scan_mask | input | 16 | Inputs included in the scan |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result code |
| next_chan | output | 4 | Channel for the next sample |
| next_is_b | output | 1 | Next sample uses the secondary selection |
| irq | output | 1 | End-of-sequence pulse |
| fill_upper | output | 1 | Upper half is filling (split mode) |
| rd_addr | input | 5 | Read address |
| rd_data | output | 10 | Buffer word at rd_addr |

## Verification
The assertions assume that cfg_split, cfg_count, scan_mask and the other configuration inputs stay constant from the release of reset until reset is asserted again. The half-ownership check and the counter bound are valid only under that assumption. The stimulus changes configuration only while rst_n is low. Each configuration then runs as a fresh episode. The bench also never issues a strobe during reset. It leaves at least one idle cycle between strobes, so that the low phase of every pulse can be observed.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int unsigned ADC_RES_W   = 10;
    localparam int unsigned ADC_DEPTH   = 32;
    localparam int unsigned ADC_NCH     = 16;
    localparam int unsigned ADC_CNT_W   = 5;

    typedef enum logic {
        MUX_A = 1'b0,
        MUX_B = 1'b1
    } mux_sel_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
    parameter int unsigned DEPTH = adc_seq_pkg::ADC_DEPTH,
    parameter int unsigned CNT_W = adc_seq_pkg::ADC_CNT_W,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_split,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             conv_done,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             seq_end,
    output logic             irq,
    output logic             fill_upper
);
    localparam int unsigned HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0]    ptr;
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic             irq;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [CNT_W:0]   full_len;
    logic [CNT_W:0]   seq_len;
    logic [CNT_W-1:0] last_idx;
    logic             at_last;

    always_comb begin
        full_len = {1'b0, cfg_count} + (CNT_W+1)'(1);
        if (cfg_split && (full_len > (CNT_W+1)'(HALF))) begin
            seq_len = (CNT_W+1)'(HALF);
        end else begin
            seq_len = full_len;
        end
        last_idx = CNT_W'(seq_len - (CNT_W+1)'(1));
        at_last  = (st_q.cnt >= last_idx);
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (conv_done) begin
            if (at_last) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
                if (cfg_split) begin
                    st_d.half = ~st_q.half;
                    st_d.ptr  = {~st_q.half, {(AW-1){1'b0}}};
                end else begin
                    st_d.half = 1'b0;
                    st_d.ptr  = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.ptr = st_q.ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en      = conv_done;
    assign wr_addr    = st_q.ptr;
    assign seq_end    = conv_done && at_last;
    assign irq        = st_q.irq;
    assign fill_upper = st_q.half;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_idx)
        else $error("sequence counter beyond programmed length");

    p_irq_follows_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(conv_done))
        else $error("interrupt without a stored result");

    p_ptr_in_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_split |-> (wr_addr[AW-1] == fill_upper))
        else $error("write pointer outside the filling half");

    p_single_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_split |-> !fill_upper)
        else $error("fill flag set in single mode");

    p_half_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_split) |-> (fill_upper != $past(fill_upper)))
        else $error("half did not swap at interrupt");
endmodule

// File: rtl/adc_seq_mux.sv
`timescale 1ns/1ps
module adc_seq_mux
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH = adc_seq_pkg::ADC_NCH,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_alt,
    input  logic           cfg_scan,
    input  logic [CW-1:0]  cfg_cha,
    input  logic [CW-1:0]  cfg_chb,
    input  logic [NCH-1:0] scan_mask,
    input  logic           conv_done,
    input  logic           restart,
    output logic [CW-1:0]  next_chan,
    output logic           next_is_b
);
    typedef struct packed {
        mux_sel_e      phase;
        logic [CW-1:0] pos;
    } mux_st_t;

    mux_st_t st_d, st_q;

    logic [CW-1:0] hit_idx, low_idx, scan_ch;
    logic          hit_any, low_any, use_scan;

    always_comb begin
        hit_any = 1'b0;
        low_any = 1'b0;
        hit_idx = '0;
        low_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (scan_mask[i] && !low_any) begin
                low_any = 1'b1;
                low_idx = CW'(i);
            end
            if (scan_mask[i] && !hit_any && (CW'(i) >= st_q.pos)) begin
                hit_any = 1'b1;
                hit_idx = CW'(i);
            end
        end
        scan_ch  = hit_any ? hit_idx : low_idx;
        use_scan = cfg_scan && low_any;
    end

    always_comb begin
        st_d = st_q;
        if (conv_done) begin
            if (restart) begin
                st_d.phase = MUX_A;
                st_d.pos   = '0;
            end else begin
                if (cfg_alt) begin
                    st_d.phase = (st_q.phase == MUX_A) ? MUX_B : MUX_A;
                end else begin
                    st_d.phase = MUX_A;
                end
                if ((st_q.phase == MUX_A) && use_scan) begin
                    st_d.pos = (scan_ch == CW'(NCH-1)) ? '0 : scan_ch + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: MUX_A, pos: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign next_is_b = (st_q.phase == MUX_B);
    assign next_chan = next_is_b ? cfg_chb : (use_scan ? scan_ch : cfg_cha);

    p_alt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_alt |-> !next_is_b)
        else $error("secondary selection without alternation");

    p_alt_swaps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_alt && $past(conv_done) && !$past(restart)) |-> (next_is_b != $past(next_is_b)))
        else $error("alternation did not swap");

    p_restart_primary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !next_is_b)
        else $error("sequence did not restart on primary");

    p_scan_hits_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_scan && (|scan_mask) && !next_is_b) |-> scan_mask[next_chan])
        else $error("scanned channel not enabled in mask");
endmodule

// File: rtl/adc_seq_buf.sv
`timescale 1ns/1ps
module adc_seq_buf #(
    parameter int unsigned DEPTH = adc_seq_pkg::ADC_DEPTH,
    parameter int unsigned RES_W = adc_seq_pkg::ADC_RES_W,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [RES_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [RES_W-1:0] rdata
);
    logic [RES_W-1:0] mem_d [DEPTH];
    logic [RES_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && (waddr == AW'(g))) begin
                mem_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rdata = mem_q[raddr];

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (mem_q[$past(waddr)] == $past(wdata)))
        else $error("stored word differs from written result");
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top #(
    parameter int unsigned RES_W = adc_seq_pkg::ADC_RES_W,
    parameter int unsigned DEPTH = adc_seq_pkg::ADC_DEPTH,
    parameter int unsigned NCH   = adc_seq_pkg::ADC_NCH,
    parameter int unsigned CNT_W = adc_seq_pkg::ADC_CNT_W,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_split,
    input  logic             cfg_alt,
    input  logic             cfg_scan,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [CW-1:0]    cfg_cha,
    input  logic [CW-1:0]    cfg_chb,
    input  logic [NCH-1:0]   scan_mask,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [CW-1:0]    next_chan,
    output logic             next_is_b,
    output logic             irq,
    output logic             fill_upper,
    input  logic [AW-1:0]    rd_addr,
    output logic [RES_W-1:0] rd_data
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          seq_end;

    adc_seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_split  (cfg_split),
        .cfg_count  (cfg_count),
        .conv_done  (conv_done),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .seq_end    (seq_end),
        .irq        (irq),
        .fill_upper (fill_upper)
    );

    adc_seq_mux #(.NCH(NCH)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_alt   (cfg_alt),
        .cfg_scan  (cfg_scan),
        .cfg_cha   (cfg_cha),
        .cfg_chb   (cfg_chb),
        .scan_mask (scan_mask),
        .conv_done (conv_done),
        .restart   (seq_end),
        .next_chan (next_chan),
        .next_is_b (next_is_b)
    );

    adc_seq_buf #(.DEPTH(DEPTH), .RES_W(RES_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (conv_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_split = 1'b0, cfg_alt = 1'b0, cfg_scan = 1'b0;
    logic [4:0]  cfg_count = '0;
    logic [3:0]  cfg_cha = 4'd3, cfg_chb = 4'd9;
    logic [15:0] scan_mask = '0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [3:0]  next_chan;
    logic        next_is_b, irq, fill_upper;
    logic [4:0]  rd_addr = '0;
    logic [9:0]  rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_mem [32];

    always #5 clk = ~clk;

    adc_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_alt(cfg_alt),
        .cfg_scan(cfg_scan), .cfg_count(cfg_count), .cfg_cha(cfg_cha),
        .cfg_chb(cfg_chb), .scan_mask(scan_mask), .conv_done(conv_done),
        .conv_data(conv_data), .next_chan(next_chan), .next_is_b(next_is_b),
        .irq(irq), .fill_upper(fill_upper), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input logic sp, input logic al, input logic sc,
                           input logic [4:0] n, input logic [15:0] m, input int nconv);
        int sb [16];
        int nset = 0;
        int lim, pos, half, aidx, exp_ch, addr;
        bit isb, last;
        logic [9:0] dat;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_split = sp; cfg_alt = al; cfg_scan = sc; cfg_count = n; scan_mask = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 irq", int'(irq), 0);
        chk("R8 fill_upper", int'(fill_upper), 0);
        chk("R8 next_is_b", int'(next_is_b), 0);
        for (int a = 0; a < 32; a++) exp_mem[a] = 0;
        rd_addr = 5'd31; #1 chk("R8 word31", int'(rd_data), 0);
        for (int b = 0; b < 16; b++) if (m[b]) begin sb[nset] = b; nset++; end
        lim = int'(n) + 1;
        if (sp && lim > 16) lim = 16;
        pos = 0; half = 0;
        for (int k = 0; k < nconv; k++) begin
            isb  = al && (pos % 2 == 1);
            aidx = al ? (pos + 1) / 2 : pos;
            if (isb) exp_ch = int'(cfg_chb);
            else if (sc && nset > 0) exp_ch = sb[aidx % nset];
            else exp_ch = int'(cfg_cha);
            chk(al ? "R6 select" : "R5 select", int'(next_is_b), int'(isb));
            chk(isb ? "R6 chan" : (sc ? "R7 chan" : "R5 chan"), int'(next_chan), exp_ch);
            dat  = 10'((k * 53 + int'(n) * 7 + 1) % 1024);
            addr = (sp ? half * 16 : 0) + pos;
            last = (pos == lim - 1);
            conv_data = dat;
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            exp_mem[addr] = int'(dat);
            chk("R1 pulse", int'(irq), int'(last));
            if (last) begin
                pos = 0;
                if (sp) half ^= 1;
            end else begin
                pos++;
            end
            chk("R4 fill", int'(fill_upper), sp ? half : 0);
            rd_addr = 5'(addr);
            #1 chk(sp ? "R3 addr" : "R2 addr", int'(rd_data), int'(dat));
            @(negedge clk);
            chk("R1 low", int'(irq), 0);
        end
        // R9: every word holds the last value written there
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            #1 chk("R9 read", int'(rd_data), exp_mem[a]);
        end
    endtask

    initial begin
        run_cfg(1'b0, 1'b0, 1'b0, 5'd0,  16'h0000, 40);
        run_cfg(1'b0, 1'b1, 1'b0, 5'd4,  16'h0000, 40);
        run_cfg(1'b0, 1'b0, 1'b1, 5'd31, 16'h8421, 70);
        run_cfg(1'b1, 1'b1, 1'b1, 5'd3,  16'h00F0, 40);
        run_cfg(1'b1, 1'b0, 1'b1, 5'd20, 16'h0000, 50);
        run_cfg(1'b1, 1'b1, 1'b1, 5'd31, 16'hA001, 50);
        run_cfg(1'b1, 1'b0, 1'b0, 5'd15, 16'h0000, 40);
        for (int n = 0; n < 32; n++) begin
            for (int s = 0; s < 2; s++) begin
                run_cfg(1'(s), 1'(n % 2), 1'((n / 2) % 2),
                        5'(n), (16'h0001 << (n % 16)) | 16'h0100, 2 * (n + 1) + 3);
            end
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule